// File: doc/BRIEF.md
# Indexed Address-Window Register Pair

This block is a small coprocessor-style control register file. It holds two 64-bit address-window descriptors and one index register that picks which descriptor the data register reaches. Software writes the index first. It then reads or writes the selected descriptor through the data register, using a full 64-bit access, a low 32-bit access or a high 32-bit access.

Each descriptor packs three fields: an enable bit, a 5-bit size code and a 32-bit base address. All three fields of both descriptors are driven continuously on dedicated ports, so an address-window comparator placed downstream can decode against them without going through software reads.

Two kinds of access are refused and flagged as unimplemented: any access made while the feature-present input is low, and any access whose register number, select or width the block does not decode. A refused access changes no state.

Top module: `saddr_window_regs`

## Requirements
- R1: After reset the index and both descriptors are zero. All window outputs, `acc_rdata` and `acc_unimpl` read 0.
- R2: The index sits at register 9, select 6. A write there looks only at `acc_wdata[5:0]` and is taken only when that value is 0 or 1; any other value leaves the index unchanged. A read returns the 6-bit index zero-extended. Only widths 0 and 2 are decoded for this register.
- R3: A full-width write (width code 2) to the data register (register 9, select 7) stores `acc_wdata & 64'h00000FFFFFFFF03F`.
- R4: A low-half write (width code 0) to the data register sign-extends `acc_wdata[31:0]` to 64 bits and then applies the same mask as R3.
- R5: A high-half write (width code 1) to the data register puts `acc_wdata[11:0]` into descriptor bits 43:32. It keeps bits 31:0 and clears bits 63:44.
- R6: Data register reads work by width. Code 0 returns bits 31:0 sign-extended. Code 1 returns bits 63:32 in the low half, with the upper half zero. Code 2 returns all 64 bits.
- R7: The index chooses the descriptor that a data access reaches. The other descriptor is neither changed nor read.
- R8: For descriptor g, `win_en[g]` is bit 0, `win_size[5g+4:5g]` is bits 5:1 and `win_base[32g+31:32g]` is bits 43:12.
- R9: While `feature_en` is 0, any strobed access raises `acc_unimpl` in the following cycle, changes no state and returns 0 read data.
- R10: A strobed access is refused with `acc_unimpl`, no state change and 0 read data in these cases: an undecoded register or select, width code 3, or a high-half access to the index.
- R11: `acc_rdata` and `acc_unimpl` are registered and reflect the access strobed in the previous cycle. `acc_unimpl` is a one-cycle pulse, and `acc_rdata` is 0 in any cycle that follows no accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 5 | Register number |
| acc_sel | input | 3 | Select code |
| acc_width | input | 2 | 0 = low 32, 1 = high 32, 2 = full 64, 3 = undecoded |
| acc_wdata | input | 64 | Write data |
| feature_en | input | 1 | Feature present; all accesses are refused when low |
| acc_rdata | output | 64 | Registered read data |
| acc_unimpl | output | 1 | Registered unimplemented-access pulse |
| win_en | output | 2 | Enable bit per descriptor |
| win_size | output | 10 | Size code per descriptor, 5 bits each |
| win_base | output | 64 | Base field per descriptor, 32 bits each |

## Verification
Directed sequences drive index values 0, 1, 2, 0x3F and 0x41. These separate the range filter on the low six bits from a check on the whole word. All-ones and sign-bit-set data is written at each width, which exposes wrong masking, a missing sign extension on the low half and a high-half write that fails to keep the low half. Writes through one index and reads through the other show that the descriptors are kept apart. A seeded random mix of register numbers, selects, widths, feature states and data then runs against a bench model; it catches mistakes in how refusals and decoding combine.

// File: rtl/saddr_window_regs.sv
`timescale 1ns/1ps
module saddr_window_regs #(
  parameter logic [4:0]  REG_NUM   = 5'd9,
  parameter logic [2:0]  SEL_INDEX = 3'd6,
  parameter logic [2:0]  SEL_DATA  = 3'd7,
  parameter logic [63:0] DATA_MASK = 64'h0000_0FFF_FFFF_F03F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [4:0]  acc_reg,
  input  logic [2:0]  acc_sel,
  input  logic [1:0]  acc_width,
  input  logic [63:0] acc_wdata,
  input  logic        feature_en,
  output logic [63:0] acc_rdata,
  output logic        acc_unimpl,
  output logic [1:0]  win_en,
  output logic [9:0]  win_size,
  output logic [63:0] win_base
);
  localparam logic [1:0] W_LO = 2'd0, W_HI = 2'd1, W_FULL = 2'd2, W_BAD = 2'd3;

  logic [5:0]  idx;
  logic [63:0] ent [2];
  logic        hit_idx, hit_dat, legal, idx_ok;
  logic [63:0] cur, wr_val, rd_val;

  assign hit_idx = (acc_reg == REG_NUM) && (acc_sel == SEL_INDEX) &&
                   (acc_width == W_LO || acc_width == W_FULL);
  assign hit_dat = (acc_reg == REG_NUM) && (acc_sel == SEL_DATA) && (acc_width != W_BAD);
  assign legal   = feature_en && (hit_idx || hit_dat);
  assign idx_ok  = (idx < 6'd2);
  assign cur     = idx_ok ? ent[idx[0]] : 64'd0;

  always_comb begin
    case (acc_width)
      W_LO:    wr_val = {{32{acc_wdata[31]}}, acc_wdata[31:0]} & DATA_MASK;
      W_HI:    wr_val = {20'd0, acc_wdata[11:0], cur[31:0]};
      default: wr_val = acc_wdata & DATA_MASK;
    endcase
  end

  always_comb begin
    if (hit_idx)                rd_val = {58'd0, idx};
    else if (acc_width == W_LO) rd_val = {{32{cur[31]}}, cur[31:0]};
    else if (acc_width == W_HI) rd_val = {32'd0, cur[63:32]};
    else                        rd_val = cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      ent[0]     <= '0;
      ent[1]     <= '0;
      acc_rdata  <= '0;
      acc_unimpl <= 1'b0;
    end else begin
      if (acc_valid && legal && acc_write) begin
        if (hit_idx && acc_wdata[5:0] <= 6'd1) idx <= acc_wdata[5:0];
        if (hit_dat && idx_ok) ent[idx[0]] <= wr_val;
      end
      acc_rdata  <= (acc_valid && legal && !acc_write) ? rd_val : 64'd0;
      acc_unimpl <= acc_valid && !legal;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_win
    assign win_en[g]          = ent[g][0];
    assign win_size[g*5 +: 5] = ent[g][5:1];
    assign win_base[g*32 +: 32] = ent[g][43:12];
  end
endmodule

// File: rtl/saddr_window_regs_chk.sv
`timescale 1ns/1ps
module saddr_window_regs_chk #(
  parameter logic [4:0] REG_NUM   = 5'd9,
  parameter logic [2:0] SEL_INDEX = 3'd6,
  parameter logic [2:0] SEL_DATA  = 3'd7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [4:0]  acc_reg,
  input logic [2:0]  acc_sel,
  input logic [1:0]  acc_width,
  input logic [63:0] acc_wdata,
  input logic        feature_en,
  input logic [63:0] acc_rdata,
  input logic        acc_unimpl,
  input logic [5:0]  idx,
  input logic [63:0] ent0,
  input logic [63:0] ent1
);
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n) idx < 6'd2);

  // R2
  idx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && feature_en && acc_reg == REG_NUM && acc_sel == SEL_INDEX &&
     (acc_width == 2'd0 || acc_width == 2'd2) && acc_wdata[5:0] > 6'd1) |=> $stable(idx));

  // R9
  feat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !feature_en) |=>
      (acc_unimpl && $stable(idx) && $stable(ent0) && $stable(ent1) && acc_rdata == 64'd0));

  // R5
  hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && feature_en && acc_reg == REG_NUM && acc_sel == SEL_DATA &&
     acc_width == 2'd1 && idx == 6'd0) |=>
      (ent0[31:0] == $past(ent0[31:0]) && ent0[63:44] == 20'd0 && $stable(ent1)));

  // R11
  unimpl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!acc_unimpl && acc_rdata == 64'd0));
endmodule

bind saddr_window_regs saddr_window_regs_chk #(
  .REG_NUM(REG_NUM), .SEL_INDEX(SEL_INDEX), .SEL_DATA(SEL_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_reg(acc_reg), .acc_sel(acc_sel), .acc_width(acc_width), .acc_wdata(acc_wdata),
  .feature_en(feature_en), .acc_rdata(acc_rdata), .acc_unimpl(acc_unimpl),
  .idx(idx), .ent0(ent[0]), .ent1(ent[1])
);

// File: tb/saddr_window_regs_test.sv
`timescale 1ns/1ps
module saddr_window_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, feature_en = 1'b1;
  logic [4:0]  acc_reg = '0;
  logic [2:0]  acc_sel = '0;
  logic [1:0]  acc_width = '0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata, win_base;
  logic        acc_unimpl;
  logic [1:0]  win_en;
  logic [9:0]  win_size;

  localparam logic [63:0] MASK = 64'h0000_0FFF_FFFF_F03F;

  int n_run = 0, n_fail = 0;
  logic [5:0]  m_idx = '0;
  logic [63:0] m_ent [2] = '{64'd0, 64'd0};

  always #2 clk = ~clk;

  saddr_window_regs uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_win(input string tag);
    for (int g = 0; g < 2; g++) begin
      chk(tag, {63'd0, win_en[g]}, {63'd0, m_ent[g][0]});
      chk(tag, {59'd0, win_size[g*5 +: 5]}, {59'd0, m_ent[g][5:1]});
      chk(tag, {32'd0, win_base[g*32 +: 32]}, {32'd0, m_ent[g][43:12]});
    end
  endtask

  task automatic acc(input logic wr, input logic [4:0] r, input logic [2:0] s,
                     input logic [1:0] w, input logic [63:0] d, input logic fe);
    logic hit_i, hit_d, legal;
    logic [63:0] cur, exp_rd;
    string tag;
    hit_i = (r == 5'd9) && (s == 3'd6) && (w == 2'd0 || w == 2'd2);
    hit_d = (r == 5'd9) && (s == 3'd7) && (w != 2'd3);
    legal = fe && (hit_i || hit_d);
    cur   = (m_idx < 6'd2) ? m_ent[m_idx[0]] : 64'd0;
    exp_rd = 64'd0;
    if (!fe)        tag = "R9";
    else if (!legal) tag = "R10";
    else if (hit_i)  tag = "R2";
    else if (wr)     tag = (w == 2'd0) ? "R4" : (w == 2'd1) ? "R5" : "R3";
    else             tag = "R6";
    if (legal && !wr) begin
      if (hit_i)          exp_rd = {58'd0, m_idx};
      else if (w == 2'd0) exp_rd = {{32{cur[31]}}, cur[31:0]};
      else if (w == 2'd1) exp_rd = {32'd0, cur[63:32]};
      else                exp_rd = cur;
    end
    if (legal && wr) begin
      if (hit_i && d[5:0] <= 6'd1) m_idx = d[5:0];
      if (hit_d && m_idx < 6'd2) begin
        if (w == 2'd0)      m_ent[m_idx[0]] = {{32{d[31]}}, d[31:0]} & MASK;
        else if (w == 2'd1) m_ent[m_idx[0]] = {20'd0, d[11:0], cur[31:0]};
        else                m_ent[m_idx[0]] = d & MASK;
      end
    end
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_reg = r; acc_sel = s;
    acc_width = w; acc_wdata = d; feature_en = fe;
    @(posedge clk); #1;
    acc_valid = 1'b0; feature_en = 1'b1;
    chk(tag, acc_rdata, exp_rd);
    chk(tag, {63'd0, acc_unimpl}, {63'd0, !legal});
    chk("R8", 64'd0, 64'd0);
    chk_win("R8");
  endtask

  task automatic idle_chk;
    @(posedge clk); #1;
    // R11: pulse is one cycle, no read data without a read
    chk("R11", {63'd0, acc_unimpl}, 64'd0);
    chk("R11", acc_rdata, 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", {62'd0, win_en}, 64'd0);
    chk("R1", {54'd0, win_size}, 64'd0);
    chk("R1", win_base, 64'd0);
    chk("R1", acc_rdata, 64'd0);
    chk("R1", {63'd0, acc_unimpl}, 64'd0);
    acc(1'b0, 5'd9, 3'd6, 2'd2, 64'd0, 1'b1);

    acc(1'b1, 5'd9, 3'd7, 2'd2, '1, 1'b1);
    acc(1'b0, 5'd9, 3'd7, 2'd2, 64'd0, 1'b1);
    chk("R3", acc_rdata, MASK);
    acc(1'b1, 5'd9, 3'd6, 2'd2, 64'h41, 1'b1);
    acc(1'b0, 5'd9, 3'd6, 2'd0, 64'd0, 1'b1);
    chk("R2", acc_rdata, 64'd1);
    acc(1'b1, 5'd9, 3'd6, 2'd0, 64'h2, 1'b1);
    acc(1'b1, 5'd9, 3'd6, 2'd2, 64'h3F, 1'b1);
    acc(1'b0, 5'd9, 3'd6, 2'd2, 64'd0, 1'b1);
    chk("R2", acc_rdata, 64'd1);
    acc(1'b1, 5'd9, 3'd7, 2'd0, 64'h1234_5678_8000_0001, 1'b1);
    chk("R4", {63'd0, win_en[1]}, 64'd1);
    acc(1'b1, 5'd9, 3'd7, 2'd1, 64'hABC5_A123, 1'b1);
    acc(1'b0, 5'd9, 3'd7, 2'd2, 64'd0, 1'b1);
    chk("R5", acc_rdata, 64'h0000_0123_8000_0001);
    acc(1'b0, 5'd9, 3'd7, 2'd0, 64'd0, 1'b1);
    chk("R6", acc_rdata, 64'hFFFF_FFFF_8000_0001);
    acc(1'b0, 5'd9, 3'd7, 2'd1, 64'd0, 1'b1);
    chk("R6", acc_rdata, 64'h123);
    // R7: entry 0 untouched by entry 1 traffic
    chk("R7", {32'd0, win_base[31:0]}, {32'd0, MASK[43:12]});
    acc(1'b1, 5'd9, 3'd7, 2'd2, 64'd0, 1'b0);
    idle_chk();
    acc(1'b1, 5'd8, 3'd7, 2'd2, 64'd0, 1'b1);
    acc(1'b1, 5'd9, 3'd6, 2'd1, 64'd0, 1'b1);
    acc(1'b1, 5'd9, 3'd7, 2'd3, 64'd0, 1'b1);
    acc(1'b0, 5'd9, 3'd5, 2'd2, 64'd0, 1'b1);
    idle_chk();
    acc(1'b1, 5'd9, 3'd6, 2'd0, 64'h0, 1'b1);
    acc(1'b0, 5'd9, 3'd7, 2'd2, 64'd0, 1'b1);
    chk("R7", acc_rdata, MASK);

    for (int i = 0; i < 400; i++) begin
      logic [4:0]  r;
      logic [2:0]  s;
      logic [63:0] d;
      r = ($urandom % 8 == 0) ? 5'($urandom) : 5'd9;
      s = ($urandom % 4 == 0) ? 3'($urandom) : 3'(6 + $urandom % 2);
      d = {$urandom, $urandom};
      if (s == 3'd6 && $urandom % 2 == 1) d[5:0] = 6'($urandom % 3);
      acc(1'($urandom), r, s, 2'($urandom), d, ($urandom % 10) != 0);
      if (i % 50 == 0) idle_chk();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule